// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block models a 16,384-bit serial nonvolatile memory that answers the Microwire three-wire protocol on chip select, serial clock and data in. It has a data output with its own enable, so the output can be released or tied to the data input to share one wire. The slave inputs are sampled by a fast system clock. Edges of the serial clock and chip select are recovered from those samples, so a host may clock the slave at any rate well below the system clock.

An organization input picks 16-bit words or 8-bit bytes. A program-enable input gates the commands that change memory. The host can read one word or stream words. It can write, erase and fill locations, and it can enable or disable writing. A parameter, counted in system clocks, sets the length of the self-timed write cycle. During that cycle the output reports busy or ready whenever chip select is high.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data output is released (do_oe_o low) and writing is disabled.
- R2: With org_i=1 the memory is 1024 words of 16 bits with a 10-bit address. With org_i=0 it is 2048 bytes with an 11-bit address. Word a occupies byte 2a (upper half) and byte 2a+1 (lower half).
- R3: Each command starts with a 1 on DI, sampled on a rising SK edge while CS is high; leading zeros are skipped. A 2-bit opcode follows, then the address MSB first, then for writes the data MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 extended. For the extended group the two address MSBs select: 11 enable writes, 00 disable writes, 10 erase all, 01 write all.
- R4: A read enables DO at the rising SK edge that carries the last address bit and drives a single 0. It then presents the addressed word MSB first, one bit per rising SK edge.
- R5: While CS stays high and SK keeps running, the next word follows the last bit at once, with no extra 0. The address steps up by one and wraps from the last location to 0.
- R6: A complete modifying command starts its self-timed cycle when CS falls. The cycle lasts WR_CYCLES system clocks and needs no SK activity. With CS high, DO is enabled and reads 0 while the cycle runs and 1 once it has ended.
- R7: After a cycle has ended, a 1 clocked in on DI with CS high releases DO at the next falling SK edge.
- R8: While writing is disabled, modifying commands are ignored. Memory is unchanged and no status is shown on DO.
- R9: Modifying commands are ignored while pe_i is 0. The enable and disable commands take effect whatever pe_i is.
- R10: Erase sets one location to all ones, and erase-all sets every location to all ones.
- R11: Write-all stores its data word (or byte) in every location.
- R12: A falling CS before a command is complete discards that command and returns the slave to wait for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all slave inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| pe_i | input | 1 | Program enable for modifying commands |
| do_o | output | 1 | Serial data out / busy-ready status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
A bit counter that drifts by one shows up at the first read. The dummy 0 lands on the wrong SK edge, or the word comes back shifted, on the very first data bit. A wrong write-enable or program-enable flag shows up right after CS is raised following the command. Either status appears when none is due, or it is missing, and a later readback differs from the model. A bad address step in sequential reads appears on the first bit of the second word, or at the wrap from the top address. A stuck busy timer shows as a missing ready level WR_CYCLES clocks after CS falls.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS = 2'b00;
  localparam logic [1:0] EX_WALL = 2'b01;
  localparam logic [1:0] EX_EALL = 2'b10;
  localparam logic [1:0] EX_WEN  = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_DATA, S_READ, S_PEND, S_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    K_ONE, K_ALL
  } mw_kind_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o,
  output logic sk_fall_o,
  output logic cs_fall_o
);
  logic [2:0] s1_q, s2_q;
  logic sk3_q, cs3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      sk3_q <= 1'b0;
      cs3_q <= 1'b0;
    end else begin
      s1_q  <= {di_i, sk_i, cs_i};
      s2_q  <= s1_q;
      sk3_q <= s2_q[1];
      cs3_q <= s2_q[0];
    end
  end

  assign cs_o      = s2_q[0];
  assign di_o      = s2_q[2];
  assign sk_rise_o = s2_q[1] & ~sk3_q;
  assign sk_fall_o = ~s2_q[1] & sk3_q;
  assign cs_fall_o = ~s2_q[0] & cs3_q;
endmodule

// File: rtl/mw_wr_timer.sv
module mw_wr_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == CW'(CYCLES - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mw_mem_array.sv
module mw_mem_array #(
  parameter int BYTES  = 2048,
  parameter int AW_B   = 11,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              org_i,
  input  logic [AW_B-1:0]   rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              commit_i,
  input  logic              all_i,
  input  logic [AW_B-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0] wdata_i
);
  localparam int BW = WORD_W / 2;

  logic [BW-1:0]   cells [BYTES];
  logic [AW_B-1:0] hi_idx, lo_idx;

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    localparam logic [AW_B-1:0] IDX = AW_B'(g);
    logic [BW-1:0] cell_q;
    logic          hit;
    assign hit = all_i || (org_i ? (IDX[AW_B-1:1] == wr_addr_i[AW_B-2:0])
                                 : (IDX == wr_addr_i));
    // nonvolatile storage: no reset
    always_ff @(posedge clk_i) begin
      if (commit_i && hit)
        cell_q <= (org_i && !IDX[0]) ? wdata_i[WORD_W-1:BW] : wdata_i[BW-1:0];
    end
    assign cells[g] = cell_q;
  end

  assign hi_idx    = org_i ? {rd_addr_i[AW_B-2:0], 1'b0} : rd_addr_i;
  assign lo_idx    = {rd_addr_i[AW_B-2:0], 1'b1};
  // byte mode returns the byte left-aligned
  assign rd_word_o = org_i ? {cells[hi_idx], cells[lo_idx]}
                           : {cells[hi_idx], {BW{1'b0}}};
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int MEM_BITS  = 16384,
  parameter int WORD_W    = 16,
  parameter int WR_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int BW    = WORD_W / 2;
  localparam int BYTES = MEM_BITS / BW;
  localparam int AW_B  = $clog2(BYTES);
  localparam int AW_W  = AW_B - 1;
  localparam int CW    = $clog2(WORD_W + 1);

  logic cs_s, di_s, sk_rise_raw, sk_rise, sk_fall, cs_fall;

  mw_sync u_sync (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .cs_o(cs_s), .di_o(di_s), .sk_rise_o(sk_rise_raw),
    .sk_fall_o(sk_fall), .cs_fall_o(cs_fall)
  );
  assign sk_rise = sk_rise_raw & cs_s;

  mw_state_e         state_q;
  mw_kind_e          kind_q;
  logic [1:0]        op_q;
  logic [AW_B-1:0]   addr_q;
  logic [WORD_W-1:0] data_q, rd_sr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_q, wen_q, stat_q, rel_q;

  logic [CW-1:0]     aw, dw;
  logic [AW_B-1:0]   addr_nxt, seq_addr, amask, rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic [1:0]        ext;
  logic              busy, done, start, rd_active;

  assign aw       = org_i ? CW'(AW_W) : CW'(AW_B);
  assign dw       = org_i ? CW'(WORD_W) : CW'(BW);
  assign amask    = org_i ? {1'b0, {AW_W{1'b1}}} : {AW_B{1'b1}};
  assign addr_nxt = {addr_q[AW_B-2:0], di_s};
  assign seq_addr = (addr_q + 1'b1) & amask;
  assign rd_addr  = (state_q == S_ADDR) ? addr_nxt : seq_addr;
  assign ext      = org_i ? addr_nxt[AW_W-1:AW_W-2] : addr_nxt[AW_B-1:AW_B-2];
  assign start    = cs_fall && (state_q == S_PEND) && wen_q && pe_i && !busy;
  assign rd_active = (state_q == S_READ);

  mw_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .done_o(done)
  );

  mw_mem_array #(.BYTES(BYTES), .AW_B(AW_B), .WORD_W(WORD_W)) u_mem (
    .clk_i, .org_i, .rd_addr_i(rd_addr), .rd_word_o(rd_word),
    .commit_i(done), .all_i(kind_q == K_ALL), .wr_addr_i(addr_q),
    .wdata_i(data_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_ONE;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_sr_q <= '0;
      cnt_q   <= '0;
      do_q    <= 1'b0;
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else if (busy) begin
      // serial side frozen during the self-timed cycle
    end else if (cs_fall) begin
      state_q <= S_IDLE;
      if (start) stat_q <= 1'b1;
    end else begin
      if (sk_fall && rel_q) begin
        stat_q <= 1'b0;
        rel_q  <= 1'b0;
      end
      if (sk_rise) begin
        case (state_q)
          S_IDLE: if (di_s) begin
            state_q <= S_OPC;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            if (stat_q) rel_q <= 1'b1;
          end
          S_OPC: begin
            op_q <= {op_q[0], di_s};
            if (cnt_q == CW'(1)) begin
              state_q <= S_ADDR;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_ADDR: begin
            addr_q <= addr_nxt;
            if (cnt_q == aw - 1'b1) begin
              cnt_q <= '0;
              case (op_q)
                OP_READ: begin
                  rd_sr_q <= rd_word;
                  do_q    <= 1'b0;
                  state_q <= S_READ;
                end
                OP_WRITE: begin
                  kind_q  <= K_ONE;
                  state_q <= S_DATA;
                end
                OP_ERASE: begin
                  kind_q  <= K_ONE;
                  data_q  <= '1;
                  state_q <= S_PEND;
                end
                default: begin
                  case (ext)
                    EX_WEN:  begin wen_q <= 1'b1; state_q <= S_HOLD; end
                    EX_WDIS: begin wen_q <= 1'b0; state_q <= S_HOLD; end
                    EX_EALL: begin kind_q <= K_ALL; data_q <= '1; state_q <= S_PEND; end
                    default: begin kind_q <= K_ALL; state_q <= S_DATA; end
                  endcase
                end
              endcase
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            data_q <= {data_q[WORD_W-2:0], di_s};
            if (cnt_q == dw - 1'b1) state_q <= S_PEND;
            else cnt_q <= cnt_q + 1'b1;
          end
          S_READ: begin
            do_q <= rd_sr_q[WORD_W-1];
            if (cnt_q == dw - 1'b1) begin
              rd_sr_q <= rd_word;
              addr_q  <= seq_addr;
              cnt_q   <= '0;
            end else begin
              rd_sr_q <= {rd_sr_q[WORD_W-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign do_oe_o = cs_s && (rd_active || stat_q);
  assign do_o    = rd_active ? do_q : !busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int WR_CYCLES = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic pe_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic wen_q,
  input logic rd_active
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_len_q <= '0;
    else         busy_len_q <= busy ? busy_len_q + 1 : '0;
  end

  // R7 and R1: output is released once CS has been low for a while
  assert_release_cs_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !$past(cs_i) && !$past(cs_i, 2) && !$past(cs_i, 3)) |-> !do_oe_o);

  assert_busy_reads_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && do_oe_o) |-> !do_o);

  assert_busy_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len_q <= WR_CYCLES);

  assert_cycle_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(wen_q) && $past(pe_i)));

  assert_dummy_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active) |-> !do_o);
endmodule

bind mw_eeprom mw_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .pe_i(pe_i),
  .do_o(do_o), .do_oe_o(do_oe_o), .busy(busy), .wen_q(wen_q),
  .rd_active(rd_active)
);

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
  localparam int WRC = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
  logic do_w, oe_w;
  logic s_do, s_oe;
  logic wen_m = 1'b0;
  logic [7:0] ref_m [2048];
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mw_eeprom #(.WR_CYCLES(WRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(do_w), .do_oe_o(oe_w)
  );

  function automatic int aw(); return org ? 10 : 11; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction
  function automatic int amask(); return org ? 1023 : 2047; endfunction
  function automatic logic [10:0] ext_addr(input logic [1:0] code);
    return 11'(code) << (aw() - 2);
  endfunction
  function automatic logic [15:0] exp_word(input int a);
    if (org) return {ref_m[2*a], ref_m[2*a+1]};
    return {8'h00, ref_m[a]};
  endfunction

  task automatic ref_apply(input bit all, input int a, input logic [15:0] d);
    for (int i = 0; i < 2048; i++) begin
      if (all || (org ? (i / 2 == a) : (i == a)))
        ref_m[i] = (org && (i % 2 == 0)) ? d[15:8] : d[7:0];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    di = b; tick(2);
    sk = 1'b1; tick(8);
    s_do = do_w; s_oe = oe_w;
    sk = 1'b0; tick(8);
  endtask

  task automatic end_cs();
    cs = 1'b0; di = 1'b0; tick(8);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [10:0] a);
    cs = 1'b1; tick(4);
    clk_bit(1'b0);  // leading zero is skipped (R3)
    clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = aw() - 1; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic do_read(input int a, input int nw, input string req);
    logic [15:0] w;
    int cur = a;
    send_cmd(2'b10, 11'(a));
    chk("R4 dummy zero", {s_oe, s_do}, 2'b10);
    for (int k = 0; k < nw; k++) begin
      w = '0;
      for (int b = 0; b < dw(); b++) begin
        clk_bit(1'b0);
        w = {w[14:0], s_do};
      end
      chk(req, 32'(w), 32'(exp_word(cur)));
      cur = (cur + 1) & amask();
    end
    end_cs();
  endtask

  task automatic modify(input logic [1:0] op, input logic [10:0] a, input logic [15:0] d,
                        input bit has_d, input bit all, input string req);
    bit run = wen_m && pe;
    send_cmd(op, a);
    if (has_d) for (int i = dw() - 1; i >= 0; i--) clk_bit(d[i]);
    end_cs();
    cs = 1'b1; tick(4);
    if (run) begin
      chk({req, " R6 busy"}, {oe_w, do_w}, 2'b10);
      tick(WRC + 10);
      chk({req, " R6 ready"}, {oe_w, do_w}, 2'b11);
      clk_bit(1'b1);
      chk("R7 release", oe_w, 1'b0);
      ref_apply(all, int'(a) & amask(), has_d ? d : 16'hFFFF);
    end else begin
      chk({req, " R8/R9 no status"}, oe_w, 1'b0);
    end
    end_cs();
  endtask

  task automatic set_wen(input bit en);
    send_cmd(2'b00, ext_addr(en ? 2'b11 : 2'b00));
    end_cs();
    wen_m = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r, a;
    logic [15:0] d;
    void'($urandom(32'd4242));
    tick(5); rst_n = 1'b1; tick(4);
    chk("R1 reset released", oe_w, 1'b0);
    cs = 1'b1; tick(4);
    chk("R1 no status after reset", oe_w, 1'b0);
    end_cs();

    // R8: writes disabled after reset
    send_cmd(2'b00, ext_addr(2'b10));
    end_cs(); cs = 1'b1; tick(4);
    chk("R8 disabled at reset", oe_w, 1'b0);
    end_cs();

    set_wen(1'b1);
    modify(2'b00, ext_addr(2'b10), 16'hFFFF, 1'b0, 1'b1, "R10 erase all");
    do_read(0, 2, "R10 erase all read");
    set_wen(1'b0);
    modify(2'b01, 11'd7, 16'h1357, 1'b1, 1'b0, "R8 write disabled");
    do_read(7, 1, "R8 unchanged");

    // R9: program enable gating; enable/disable independent of pe
    pe = 1'b0;
    set_wen(1'b1);
    modify(2'b01, 11'd9, 16'hBEEF, 1'b1, 1'b0, "R9 pe low write");
    do_read(9, 1, "R9 unchanged");
    pe = 1'b1;
    modify(2'b01, 11'd9, 16'hBEEF, 1'b1, 1'b0, "R9 pe high write");
    do_read(9, 1, "R9 written");

    modify(2'b01, 11'd5, 16'h1234, 1'b1, 1'b0, "R3 write word");
    modify(2'b11, 11'd9, 16'h0000, 1'b0, 1'b0, "R10 erase");
    do_read(4, 6, "R5 sequential word");

    // R12: aborted commands
    cs = 1'b1; tick(4);
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    end_cs();
    send_cmd(2'b01, 11'd5);
    for (int i = 0; i < 6; i++) clk_bit(1'b1);
    end_cs(); cs = 1'b1; tick(4);
    chk("R12 partial write no status", oe_w, 1'b0);
    end_cs();
    do_read(5, 1, "R12 unchanged");

    // random word-mode traffic
    for (int k = 0; k < 12; k++) begin
      r = int'($urandom % 3); a = int'($urandom) & amask(); d = 16'($urandom);
      case (r)
        0: modify(2'b01, 11'(a), d, 1'b1, 1'b0, "R3 rand write");
        1: modify(2'b11, 11'(a), d, 1'b0, 1'b0, "R10 rand erase");
        default: do_read(a, 2, "R4 rand read");
      endcase
    end
    do_read(1022, 3, "R5 word wrap");

    // byte organisation
    org = 1'b0; tick(4);
    do_read(10, 2, "R2 byte view of word");
    modify(2'b01, 11'd2047, 16'h00C3, 1'b1, 1'b0, "R2 byte write");
    do_read(2046, 3, "R5 byte wrap");
    for (int k = 0; k < 10; k++) begin
      r = int'($urandom % 3); a = int'($urandom) & amask(); d = 16'($urandom);
      case (r)
        0: modify(2'b01, 11'(a), d, 1'b1, 1'b0, "R2 rand byte write");
        1: modify(2'b11, 11'(a), d, 1'b0, 1'b0, "R10 rand byte erase");
        default: do_read(a, 2, "R2 rand byte read");
      endcase
    end
    modify(2'b00, ext_addr(2'b01), 16'h005A, 1'b1, 1'b1, "R11 write all byte");
    do_read(1500, 2, "R11 byte fill");
    org = 1'b1; tick(4);
    modify(2'b00, ext_addr(2'b01), 16'hA55A, 1'b1, 1'b1, "R11 write all word");
    do_read(300, 2, "R11 word fill");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule